// File: doc/BRIEF.md
# Board Interrupt Aggregator with Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from board peripherals and presents the most urgent one to the CPU as a 4-bit interrupt level code. Each request line owns one bit of a 16-bit status word and one priority level. The map from line to bit to level is fixed and non-linear. A software-writable 16-bit enable mask gates the status word. The block takes the smallest level number among the sources whose status and enable bits are both set, and drives that number XOR 15 onto `irl_code`. When nothing is pending the code is 0.

The same 64-byte register window, reached by 16-bit accesses at byte offsets, holds the enable mask, a general-purpose output register, a fixed version word and a power-off control. A write to the power-off control with bit 0 set produces a one-cycle `shutdown_pulse`. A small state machine drives this pulse. It has two states. `SD_IDLE` waits for a qualifying write and moves to `SD_FIRE` when one arrives (transition ARM). `SD_FIRE` asserts the pulse for exactly one cycle and always returns to `SD_IDLE` (transition DONE). A qualifying write that lands while in `SD_FIRE` is dropped.

Request line `src_req[k]` carries priority level k. The line-to-bit map is the one listed in R1.

Top module: `board_irq_aggregator`

## Requirements
- R1: Source k has priority level k. Its status bit is: k=0 bit 11, k=1 bit 9, k=2 bit 8, k=3 bit 12, k=4 bit 10, k=5 bit 6, k=6 bit 5, k=7 bit 4, k=8 bit 7, k=9 bit 14, k=10 bit 13, k=11 bit 0, k=12 bit 15. When source k alone is pending, `irl_code` equals k XOR 15.
- R2: A source is pending only when its request is high and the enable mask bit at its status position is 1. Mask bits 1, 2 and 3 belong to no source and never make anything pending.
- R3: When several sources are pending, the one with the smallest level wins.
- R4: With no source pending, `irl_code` is 0.
- R5: `irl_code` is registered. It reflects the requests and mask as they stood just before each rising clock edge, and it does not change between edges.
- R6: Requests are not latched. When a request drops, its effect is gone after the next edge.
- R7: Offset 0x00 is the 16-bit enable mask. It is read/write, and a new value takes effect on `irl_code` one edge after the write.
- R8: Offset 0x36 is a 16-bit read/write output register, driven on `gpo`. Writing it has no effect on `irl_code`.
- R9: Offset 0x30 reads 0. A write there with bit 0 = 1 makes `shutdown_pulse` high for exactly the one cycle after the write edge. A write with bit 0 = 0 gives no pulse.
- R10: Offset 0x32 reads 0x0010, and writes to it leave it unchanged.
- R11: Every other offset in the window reads 0. Writes to those offsets change neither the mask nor the output register.
- R12: After reset the mask and the output register are 0, `irl_code` is 0 and `shutdown_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 13 | Level-sensitive requests; bit k has priority level k |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irl_code | output | 4 | Encoded interrupt level (winning level XOR 15, 0 if none) |
| gpo | output | 16 | Contents of the output register |
| shutdown_pulse | output | 1 | One-cycle power-off request |

## Verification
The bench sweeps every single source and every pair of sources, so a bit-map or level table with any entry swapped, or a priority comparison that lets the larger level win, gives a wrong code. It gates each source alone through the mask and also masks each one out. A design that ignored the mask, or that enabled a source through a neighbouring bit, would show a nonzero code where 0 is due. It samples just before and just after the edge that follows a request change. An unregistered output, or one delayed by an extra stage, fails here, and so does a design that latches requests. It also writes all 0xFFFF to every unassigned offset, writes to the version word and writes to the power-off control with bit 0 clear. A loose address decode would then corrupt the mask or the output register, or fire a spurious shutdown.

// File: rtl/bic_pkg.sv
package bic_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned WIN_ADDR_W = 6;
    localparam int unsigned SRC_COUNT  = 13;
    localparam int unsigned LEVEL_W    = 4;

    localparam logic [WIN_ADDR_W-1:0] OFF_ENABLE = 6'h00;
    localparam logic [WIN_ADDR_W-1:0] OFF_POWER  = 6'h30;
    localparam logic [WIN_ADDR_W-1:0] OFF_VER    = 6'h32;
    localparam logic [WIN_ADDR_W-1:0] OFF_GPO    = 6'h36;

    localparam logic [LEVEL_W-1:0] LEVEL_NONE = 4'hF;

    typedef enum logic {
        SD_IDLE = 1'b0,
        SD_FIRE = 1'b1
    } sd_state_e;

    // Status bit owned by the source with priority level lvl.
    function automatic logic [3:0] src_bit(input logic [3:0] lvl);
        logic [3:0] b;
        unique case (lvl)
            4'd0:    b = 4'd11;
            4'd1:    b = 4'd9;
            4'd2:    b = 4'd8;
            4'd3:    b = 4'd12;
            4'd4:    b = 4'd10;
            4'd5:    b = 4'd6;
            4'd6:    b = 4'd5;
            4'd7:    b = 4'd4;
            4'd8:    b = 4'd7;
            4'd9:    b = 4'd14;
            4'd10:   b = 4'd13;
            4'd11:   b = 4'd0;
            4'd12:   b = 4'd15;
            default: b = 4'd1;
        endcase
        return b;
    endfunction

    // Priority level carried by a status bit; unowned bits rank lowest.
    function automatic logic [3:0] bit_level(input logic [3:0] b);
        logic [3:0] l;
        unique case (b)
            4'd11:   l = 4'd0;
            4'd9:    l = 4'd1;
            4'd8:    l = 4'd2;
            4'd12:   l = 4'd3;
            4'd10:   l = 4'd4;
            4'd6:    l = 4'd5;
            4'd5:    l = 4'd6;
            4'd4:    l = 4'd7;
            4'd7:    l = 4'd8;
            4'd14:   l = 4'd9;
            4'd13:   l = 4'd10;
            4'd0:    l = 4'd11;
            4'd15:   l = 4'd12;
            default: l = LEVEL_NONE;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/bic_status_map.sv
module bic_status_map
    import bic_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_COUNT,
    parameter int unsigned DATA_W  = WORD_W
) (
    input  logic [NUM_SRC-1:0] src_req,
    output logic [DATA_W-1:0]  status
);

    // Place each request at its fixed status position; unowned bits stay 0.
    always_comb begin
        status = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            status[src_bit(4'(k))] = src_req[k];
        end
    end

endmodule

// File: rtl/bic_level_encoder.sv
module bic_level_encoder
    import bic_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LVL_W  = LEVEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] enable,
    output logic [LVL_W-1:0]  irl_code
);

    localparam logic [LVL_W-1:0] IDLE_LEVEL = {LVL_W{1'b1}};

    logic [DATA_W-1:0] pend;
    logic [LVL_W-1:0]  lvl_of [DATA_W];
    logic [LVL_W-1:0]  best;

    assign pend = status & enable;

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_lvl
            assign lvl_of[g] = LVL_W'(bit_level(4'(g)));
        end
    endgenerate

    // Smallest level among pending bits; unowned bits rank as idle.
    always_comb begin
        best = IDLE_LEVEL;
        for (int b = 0; b < DATA_W; b++) begin
            if (pend[b] && (lvl_of[b] < best)) begin
                best = lvl_of[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irl_code <= '0;
        end else begin
            irl_code <= best ^ IDLE_LEVEL;
        end
    end

endmodule

// File: rtl/bic_reg_window.sv
module bic_reg_window
    import bic_pkg::*;
#(
    parameter int unsigned ADDR_W  = WIN_ADDR_W,
    parameter int unsigned DATA_W  = WORD_W,
    parameter logic [15:0] VERSION = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] gpo_q,
    output logic              shutdown_pulse
);

    logic      wr_enable, wr_gpo, wr_power_arm;
    sd_state_e sd_state, sd_next;

    assign wr_enable    = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_ENABLE));
    assign wr_gpo       = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_GPO));
    assign wr_power_arm = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_POWER))
                          && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            gpo_q  <= '0;
        end else begin
            if (wr_enable) mask_q <= bus_wdata;
            if (wr_gpo)    gpo_q  <= bus_wdata;
        end
    end

    // Shutdown sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sd_state <= SD_IDLE;
        else        sd_state <= sd_next;
    end

    // Shutdown sequencer: transitions ARM and DONE
    always_comb begin
        sd_next = sd_state;
        unique case (sd_state)
            SD_IDLE: if (wr_power_arm) sd_next = SD_FIRE;
            SD_FIRE: sd_next = SD_IDLE;
            default: sd_next = SD_IDLE;
        endcase
    end

    // Shutdown sequencer: outputs
    always_comb begin
        unique case (sd_state)
            SD_FIRE: shutdown_pulse = 1'b1;
            default: shutdown_pulse = 1'b0;
        endcase
    end

    // Read mux; power control and unowned offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == ADDR_W'(OFF_ENABLE))   bus_rdata = mask_q;
            else if (bus_addr == ADDR_W'(OFF_GPO)) bus_rdata = gpo_q;
            else if (bus_addr == ADDR_W'(OFF_VER)) bus_rdata = DATA_W'(VERSION);
        end
    end

endmodule

// File: rtl/board_irq_aggregator.sv
module board_irq_aggregator
    import bic_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_COUNT,
    parameter int unsigned ADDR_W  = WIN_ADDR_W,
    parameter int unsigned DATA_W  = WORD_W,
    parameter int unsigned LVL_W   = LEVEL_W,
    parameter logic [15:0] VERSION = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [LVL_W-1:0]   irl_code,
    output logic [DATA_W-1:0]  gpo,
    output logic               shutdown_pulse
);

    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] mask_q;

    bic_status_map #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_map (
        .src_req (src_req),
        .status  (status_w)
    );

    bic_reg_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_sel        (bus_sel),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .mask_q         (mask_q),
        .gpo_q          (gpo),
        .shutdown_pulse (shutdown_pulse)
    );

    bic_level_encoder #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status_w),
        .enable   (mask_q),
        .irl_code (irl_code)
    );

endmodule

// File: rtl/bic_checker.sv
module bic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [12:0] src_req,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [5:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic [3:0]  irl_code,
    input logic        shutdown_pulse,
    input logic [15:0] mask_q
);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_pulse |=> !shutdown_pulse);

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_pulse) |-> $past(bus_sel && bus_we && bus_addr == 6'h30 && bus_wdata[0]));

    assert_power_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 6'h30) |-> bus_rdata == 16'h0000);

    assert_version_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 6'h32) |-> bus_rdata == 16'h0010);

    assert_quiet_gives_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_req) == 13'd0) |-> irl_code == 4'h0);

    assert_top_source_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_req[0]) && $past(mask_q[11])) |-> irl_code == 4'hF);

    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 6'h00) |=> mask_q == $past(bus_wdata));

endmodule

bind board_irq_aggregator bic_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_req        (src_req),
    .bus_sel        (bus_sel),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .irl_code       (irl_code),
    .shutdown_pulse (shutdown_pulse),
    .mask_q         (mask_q)
);

// File: tb/board_irq_aggregator_bench.sv
`timescale 1ns/1ps
module board_irq_aggregator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irl_code;
    logic [15:0] gpo;
    logic        shutdown_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    board_irq_aggregator u_board_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irl_code(irl_code), .gpo(gpo), .shutdown_pulse(shutdown_pulse)
    );

    // Status bit per source level, from R1.
    function automatic logic [15:0] bit_of(input int k);
        case (k)
            0: return 16'h0800;  1: return 16'h0200;  2: return 16'h0100;
            3: return 16'h1000;  4: return 16'h0400;  5: return 16'h0040;
            6: return 16'h0020;  7: return 16'h0010;  8: return 16'h0080;
            9: return 16'h4000; 10: return 16'h2000; 11: return 16'h0001;
            default: return 16'h8000;
        endcase
    endfunction

    // Expected code from requests and mask (R1 to R4).
    function automatic logic [3:0] expect_code(input logic [12:0] req, input logic [15:0] msk);
        for (int k = 0; k < 13; k++)
            if (req[k] && ((msk & bit_of(k)) != 0)) return 4'(k) ^ 4'hF;
        return 4'h0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] msk;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R12 reset state
        check("R12 irl", irl_code, 0);
        check("R12 pulse", shutdown_pulse, 0);
        rd(6'h00, d); check("R12 mask", d, 0);
        rd(6'h36, d); check("R12 gpo", d, 0);

        // R1 each source alone
        msk = 16'hFFFF; wr(6'h00, msk);
        for (int k = 0; k < 13; k++) begin
            src_req = 13'(1 << k); tick(); tick();
            check("R1 single", irl_code, k ^ 15);
        end
        // R3 every pair
        for (int i = 0; i < 13; i++)
            for (int j = i + 1; j < 13; j++) begin
                src_req = 13'((1 << i) | (1 << j)); tick(); tick();
                check("R3 pair", irl_code, expect_code(src_req, msk));
            end
        // R2 mask gating
        src_req = '1;
        for (int k = 0; k < 13; k++) begin
            wr(6'h00, bit_of(k)); tick();
            check("R2 only", irl_code, k ^ 15);
        end
        for (int k = 0; k < 13; k++) begin
            src_req = 13'(1 << k);
            wr(6'h00, ~bit_of(k)); tick();
            check("R2 masked", irl_code, 0);
        end
        src_req = '1; wr(6'h00, 16'h000E); tick();
        check("R2 unowned", irl_code, 0);

        // R4 nothing requested
        src_req = '0; wr(6'h00, 16'hFFFF); tick();
        check("R4 idle", irl_code, 0);

        // R5 registered timing
        src_req = 13'(1 << 5); #1;
        check("R5 before edge", irl_code, 0);
        tick();
        check("R5 after edge", irl_code, 5 ^ 15);
        // R6 no latching
        src_req = '0; tick();
        check("R6 drop", irl_code, 0);

        // R7 mask readback
        wr(6'h00, 16'hA5C3); rd(6'h00, d); check("R7 readback", d, 16'hA5C3);
        src_req = 13'(1 << 9); tick();
        check("R7 effect", irl_code, expect_code(src_req, 16'hA5C3));

        // R8 output register
        wr(6'h36, 16'h1234); rd(6'h36, d); check("R8 readback", d, 16'h1234);
        check("R8 gpo", gpo, 16'h1234);
        tick(); check("R8 no effect", irl_code, expect_code(src_req, 16'hA5C3));

        // R9 power control
        rd(6'h30, d); check("R9 read", d, 0);
        wr(6'h30, 16'h0002); check("R9 bit0 clear", shutdown_pulse, 0);
        wr(6'h30, 16'h0001); check("R9 pulse", shutdown_pulse, 1);
        tick(); check("R9 one cycle", shutdown_pulse, 0);

        // R10 version
        rd(6'h32, d); check("R10 read", d, 16'h0010);
        wr(6'h32, 16'hFFFF); rd(6'h32, d); check("R10 after write", d, 16'h0010);

        // R11 unowned offsets
        for (int a = 2; a < 64; a += 2) begin
            if (a != 6'h30 && a != 6'h32 && a != 6'h36) begin
                wr(6'(a), 16'hFFFF);
                rd(6'(a), d); check("R11 read", d, 0);
            end
        end
        check("R11 pulse", shutdown_pulse, 0);
        rd(6'h00, d); check("R11 mask kept", d, 16'hA5C3);
        rd(6'h36, d); check("R11 gpo kept", d, 16'h1234);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule